// File: doc/BRIEF.md
# Multi-phase SPI master sequencer

The block is an SPI master that runs one transaction as a chain of optional phases. In order, these are command, address, write, dummy and read. A transaction is launched with a single-cycle start request. The phase lengths, the mode and the data words are sampled in that cycle and held until the transaction ends. Any phase with a length of zero is skipped. Command, address and transmit data come from parallel words. Each field is sent from its low `len` bits, most significant of those bits first. Received bits are shifted into a parallel receive word.

In half-duplex mode, the write and read phases run separately, each with its own length, and the dummy phase sits between them. In full-duplex mode, the data phase shifts out and in at the same time. It then lasts only for the transmit length, and the receive length limits how many of the incoming bits are kept. The serial clock idles low (mode 0), and its half period is a fixed number of system clocks.

Top module: `spi_phase_master`

## Requirements
- R1: After reset, and whenever idle: cs_no=1, sclk_o=0, mosi_o=0, busy_o=0, done_o=0.
- R2: In half-duplex mode, bits leave in the order command (cmd_len_i bits), address (addr_len_i bits), write (tx_len_i bits), dummy, read. Each field is taken from its low len bits, bit len-1 first, and a zero-length phase produces no clocks.
- R3: Lengths above their maximum are reduced to the maximum: command 16, address 64, transmit and receive 32.
- R4: During the dummy phase (dummy_len_i clocks) and the half-duplex read phase, mosi_o is 0.
- R5: In half-duplex mode, rx_data_o holds the rx_len_i read-phase bits, with the first received bit in position rx_len_i-1 and zeros above. MISO outside the read phase is not stored.
- R6: In full-duplex mode (full_duplex_i=1), the clock count is command+address+transmit length, with no dummy or separate read phase. rx_data_o keeps the first min(rx_len_i, tx_len_i) data-phase bits, and later bits are discarded.
- R7: mosi_o changes only while sclk_o is low. MISO is sampled at the rising sclk_o transition, and sclk_o is high only while cs_no is low.
- R8: With total bit count N and half period H, cs_no is low and busy_o is high from the cycle after start is accepted, for (2N+1)*H cycles. done_o pulses for exactly one cycle as cs_no returns high.
- R9: start_i and the configuration inputs are ignored while busy_o=1. A start request during a transaction neither changes it nor starts a second one.
- R10: If every phase length is zero, cs_no goes low for H cycles, no sclk_o edge occurs, and done_o pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch request, sampled when idle |
| full_duplex_i | input | 1 | 1 = combined data phase, 0 = separate write/read |
| cmd_len_i | input | 5 | Command bit count (0..16) |
| addr_len_i | input | 7 | Address bit count (0..64) |
| tx_len_i | input | 6 | Write / full-duplex data bit count (0..32) |
| rx_len_i | input | 6 | Read length, or kept-bit limit in full duplex (0..32) |
| dummy_len_i | input | 8 | Dummy clock count, half duplex only |
| cmd_i | input | 16 | Command word |
| addr_i | input | 64 | Address word |
| tx_data_i | input | 32 | Transmit word |
| miso_i | input | 1 | Serial data from slave |
| sclk_o | output | 1 | Serial clock, idles low |
| mosi_o | output | 1 | Serial data to slave |
| cs_no | output | 1 | Chip select, active low |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_data_o | output | 32 | Receive word |

## Verification
The bench holds start for one cycle and counts negative clock edges from there. done_o must first appear at count (2N+1)*H+1, and busy_o/cs_no must change state at count 1. All other results are read at that done cycle, with the done pulse checked gone one cycle later. These results are the rx_data_o word, the number of rising sclk_o edges, and the MOSI bit captured at each rising edge. A slave model in the bench changes MISO on each falling sclk_o edge from a random pattern, so the expected receive word follows directly from the pattern index of every bit. A start injected mid-transaction is judged by the same due-cycle checks, followed by eight quiet cycles.

// File: rtl/spi_pm_pkg.sv
package spi_pm_pkg;

  localparam int NUM_PH = 5;

  // order of values is the half-duplex phase order
  typedef enum logic [2:0] {
    PH_CMD   = 3'd0,
    PH_ADDR  = 3'd1,
    PH_WR    = 3'd2,
    PH_DUMMY = 3'd3,
    PH_RD    = 3'd4,
    PH_END   = 3'd5
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LO,
    ST_HI
  } seq_st_e;

  function automatic phase_e first_phase(logic [NUM_PH-1:0] nz);
    phase_e r;
    r = PH_END;
    for (int p = NUM_PH - 1; p >= 0; p--) begin
      if (nz[p]) r = phase_e'(3'(p));
    end
    return r;
  endfunction

  function automatic phase_e next_phase(phase_e cur, logic [NUM_PH-1:0] nz);
    phase_e r;
    r = PH_END;
    for (int p = NUM_PH - 1; p >= 0; p--) begin
      if (nz[p] && (p > int'(cur))) r = phase_e'(3'(p));
    end
    return r;
  endfunction

endpackage

// File: rtl/spi_pm_tick.sv
module spi_pm_tick #(
  parameter int HALF_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic tick_o
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i || tick_o || !run_i) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // the divider only runs inside a transaction
  p_cnt_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));

endmodule

// File: rtl/spi_pm_seq.sv
module spi_pm_seq
  import spi_pm_pkg::*;
#(
  parameter int LW = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  input  logic [NUM_PH-1:0][LW-1:0]    len_i,
  input  logic                         tick_i,
  output phase_e                       phase_o,
  output logic [LW-1:0]                idx_o,
  output logic                         load_o,
  output logic                         rise_o,
  output logic                         sclk_o,
  output logic                         cs_no,
  output logic                         busy_o,
  output logic                         done_o
);

  seq_st_e                    st_q;
  phase_e                     ph_q;
  logic [LW-1:0]              idx_q;
  logic [NUM_PH-1:0][LW-1:0]  len_q;
  logic                       sclk_q, cs_n_q, done_q;

  logic [NUM_PH-1:0] nz_d, nz_q;
  phase_e            first_ph, nxt_ph;
  logic [LW-1:0]     first_len, nxt_len;
  logic              fall, finish;

  always_comb begin
    for (int p = 0; p < NUM_PH; p++) begin
      nz_d[p] = |len_i[p];
      nz_q[p] = |len_q[p];
    end
  end

  assign first_ph  = first_phase(nz_d);
  assign nxt_ph    = next_phase(ph_q, nz_q);
  assign first_len = (first_ph == PH_END) ? '0 : len_i[first_ph];
  assign nxt_len   = (nxt_ph == PH_END) ? '0 : len_q[nxt_ph];

  assign load_o = (st_q == ST_IDLE) && start_i;
  assign rise_o = (st_q == ST_LO) && tick_i && (ph_q != PH_END);
  assign fall   = (st_q == ST_HI) && tick_i;
  assign finish = (st_q == ST_LO) && tick_i && (ph_q == PH_END);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_END;
      idx_q  <= '0;
      len_q  <= '0;
      sclk_q <= 1'b0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (load_o) begin
        len_q  <= len_i;
        ph_q   <= first_ph;
        idx_q  <= (first_ph == PH_END) ? '0 : first_len - 1'b1;
        st_q   <= ST_LO;
        cs_n_q <= 1'b0;
      end else if (rise_o) begin
        st_q   <= ST_HI;
        sclk_q <= 1'b1;
      end else if (fall) begin
        st_q   <= ST_LO;
        sclk_q <= 1'b0;
        if (idx_q == '0) begin
          ph_q  <= nxt_ph;
          idx_q <= (nxt_ph == PH_END) ? '0 : nxt_len - 1'b1;
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end else if (finish) begin
        st_q   <= ST_IDLE;
        cs_n_q <= 1'b1;
      end
    end
  end

  assign phase_o = ph_q;
  assign idx_o   = idx_q;
  assign sclk_o  = sclk_q;
  assign cs_no   = cs_n_q;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = done_q;

  p_idx_in_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (ph_q != PH_END)) |-> (idx_q < len_q[ph_q]));

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(len_q));

  p_sclk_in_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_cs_release_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |-> done_o);

  p_cs_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == !cs_no);

endmodule

// File: rtl/spi_pm_datapath.sv
module spi_pm_datapath
  import spi_pm_pkg::*;
#(
  parameter int CMD_MAX  = 16,
  parameter int ADDR_MAX = 64,
  parameter int DATA_MAX = 32,
  parameter int LW       = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                rise_i,
  input  phase_e              phase_i,
  input  logic [LW-1:0]       idx_i,
  input  logic                fd_i,
  input  logic [LW-1:0]       rx_lim_i,
  input  logic [CMD_MAX-1:0]  cmd_i,
  input  logic [ADDR_MAX-1:0] addr_i,
  input  logic [DATA_MAX-1:0] tx_i,
  input  logic                miso_i,
  output logic                mosi_o,
  output logic [DATA_MAX-1:0] rx_data_o
);

  localparam int CMD_IW  = $clog2(CMD_MAX);
  localparam int ADDR_IW = $clog2(ADDR_MAX);
  localparam int DATA_IW = $clog2(DATA_MAX);

  logic [CMD_MAX-1:0]  cmd_q;
  logic [ADDR_MAX-1:0] addr_q;
  logic [DATA_MAX-1:0] tx_q;
  logic [DATA_MAX-1:0] rx_q;
  logic                fd_q;
  logic [LW-1:0]       rx_lim_q;
  logic [LW-1:0]       rx_cnt_q;
  logic                capture;

  // phase and index only move while sclk is low, so mosi follows suit
  always_comb begin
    unique case (phase_i)
      PH_CMD:  mosi_o = cmd_q[idx_i[CMD_IW-1:0]];
      PH_ADDR: mosi_o = addr_q[idx_i[ADDR_IW-1:0]];
      PH_WR:   mosi_o = tx_q[idx_i[DATA_IW-1:0]];
      default: mosi_o = 1'b0;
    endcase
  end

  assign capture = rise_i && (fd_q ? ((phase_i == PH_WR) && (rx_cnt_q < rx_lim_q))
                                   : (phase_i == PH_RD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      addr_q   <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
      fd_q     <= 1'b0;
      rx_lim_q <= '0;
      rx_cnt_q <= '0;
    end else if (load_i) begin
      cmd_q    <= cmd_i;
      addr_q   <= addr_i;
      tx_q     <= tx_i;
      fd_q     <= fd_i;
      rx_lim_q <= rx_lim_i;
      rx_q     <= '0;
      rx_cnt_q <= '0;
    end else if (capture) begin
      rx_q     <= {rx_q[DATA_MAX-2:0], miso_i};
      rx_cnt_q <= rx_cnt_q + 1'b1;
    end
  end

  assign rx_data_o = rx_q;

  p_rx_cnt_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_cnt_q <= rx_lim_q);

  p_hd_no_stray_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !fd_q && (phase_i != PH_RD) && !load_i) |=> $stable(rx_q));

endmodule

// File: rtl/spi_phase_master.sv
module spi_phase_master
  import spi_pm_pkg::*;
#(
  parameter int HALF_CYC  = 2,
  parameter int CMD_MAX   = 16,
  parameter int ADDR_MAX  = 64,
  parameter int DATA_MAX  = 32,
  parameter int DUMMY_MAX = 255,
  localparam int CMD_LW   = $clog2(CMD_MAX + 1),
  localparam int ADDR_LW  = $clog2(ADDR_MAX + 1),
  localparam int DATA_LW  = $clog2(DATA_MAX + 1),
  localparam int DUMMY_LW = $clog2(DUMMY_MAX + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                full_duplex_i,
  input  logic [CMD_LW-1:0]   cmd_len_i,
  input  logic [ADDR_LW-1:0]  addr_len_i,
  input  logic [DATA_LW-1:0]  tx_len_i,
  input  logic [DATA_LW-1:0]  rx_len_i,
  input  logic [DUMMY_LW-1:0] dummy_len_i,
  input  logic [CMD_MAX-1:0]  cmd_i,
  input  logic [ADDR_MAX-1:0] addr_i,
  input  logic [DATA_MAX-1:0] tx_data_i,
  input  logic                miso_i,
  output logic                sclk_o,
  output logic                mosi_o,
  output logic                cs_no,
  output logic                busy_o,
  output logic                done_o,
  output logic [DATA_MAX-1:0] rx_data_o
);

  localparam int M1      = (CMD_MAX > ADDR_MAX) ? CMD_MAX : ADDR_MAX;
  localparam int M2      = (DATA_MAX > DUMMY_MAX) ? DATA_MAX : DUMMY_MAX;
  localparam int LEN_MAX = (M1 > M2) ? M1 : M2;
  localparam int LW      = $clog2(LEN_MAX + 1);

  function automatic logic [LW-1:0] clip(int v, int mx);
    return LW'((v > mx) ? mx : v);
  endfunction

  logic [NUM_PH-1:0][LW-1:0] len_sel;
  logic [LW-1:0]             rx_lim;
  phase_e                    phase;
  logic [LW-1:0]             idx;
  logic                      load, rise, tick;

  // full duplex folds the read into the write phase and drops the dummy
  always_comb begin
    len_sel           = '0;
    len_sel[PH_CMD]   = clip(int'(cmd_len_i), CMD_MAX);
    len_sel[PH_ADDR]  = clip(int'(addr_len_i), ADDR_MAX);
    len_sel[PH_WR]    = clip(int'(tx_len_i), DATA_MAX);
    len_sel[PH_DUMMY] = full_duplex_i ? '0 : clip(int'(dummy_len_i), DUMMY_MAX);
    len_sel[PH_RD]    = full_duplex_i ? '0 : clip(int'(rx_len_i), DATA_MAX);
  end

  assign rx_lim = clip(int'(rx_len_i), DATA_MAX);

  spi_pm_tick #(.HALF_CYC(HALF_CYC)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_o),
    .clr_i  (load),
    .tick_o (tick)
  );

  spi_pm_seq #(.LW(LW)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .len_i   (len_sel),
    .tick_i  (tick),
    .phase_o (phase),
    .idx_o   (idx),
    .load_o  (load),
    .rise_o  (rise),
    .sclk_o  (sclk_o),
    .cs_no   (cs_no),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  spi_pm_datapath #(
    .CMD_MAX  (CMD_MAX),
    .ADDR_MAX (ADDR_MAX),
    .DATA_MAX (DATA_MAX),
    .LW       (LW)
  ) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (load),
    .rise_i    (rise),
    .phase_i   (phase),
    .idx_i     (idx),
    .fd_i      (full_duplex_i),
    .rx_lim_i  (rx_lim),
    .cmd_i     (cmd_i),
    .addr_i    (addr_i),
    .tx_i      (tx_data_i),
    .miso_i    (miso_i),
    .mosi_o    (mosi_o),
    .rx_data_o (rx_data_o)
  );

  p_idle_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (cs_no && !sclk_o && !mosi_o));

  p_mosi_stable_at_rise_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(mosi_o));

  p_mosi_stable_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

endmodule

// File: tb/spi_phase_master_bench.sv
module spi_phase_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        full_duplex_i = 1'b0;
  logic [4:0]  cmd_len_i = '0;
  logic [6:0]  addr_len_i = '0;
  logic [5:0]  tx_len_i = '0;
  logic [5:0]  rx_len_i = '0;
  logic [7:0]  dummy_len_i = '0;
  logic [15:0] cmd_i = '0;
  logic [63:0] addr_i = '0;
  logic [31:0] tx_data_i = '0;
  logic        miso_i = 1'b0;
  logic        sclk_o, mosi_o, cs_no, busy_o, done_o;
  logic [31:0] rx_data_o;

  int checks = 0;
  int failures = 0;

  logic [511:0] miso_pat = '0;
  logic         mosi_seen [0:511];
  int           rises = 0;
  logic         cs_prev = 1'b1;
  logic         sclk_prev = 1'b0;
  int           mosi_bad = 0;
  logic         smp_mosi = 1'b0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  spi_phase_master #(.HALF_CYC(HALF)) u_spi_phase_master (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (start_i),
    .full_duplex_i (full_duplex_i),
    .cmd_len_i     (cmd_len_i),
    .addr_len_i    (addr_len_i),
    .tx_len_i      (tx_len_i),
    .rx_len_i      (rx_len_i),
    .dummy_len_i   (dummy_len_i),
    .cmd_i         (cmd_i),
    .addr_i        (addr_i),
    .tx_data_i     (tx_data_i),
    .miso_i        (miso_i),
    .sclk_o        (sclk_o),
    .mosi_o        (mosi_o),
    .cs_no         (cs_no),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .rx_data_o     (rx_data_o)
  );

  // slave model: record mosi at each rise, present next miso bit at each fall
  always @(sclk_o or cs_no) begin
    if (cs_no != cs_prev) begin
      cs_prev = cs_no;
      if (!cs_no) begin
        rises  = 0;
        miso_i = miso_pat[0];
      end
    end
    if (sclk_o != sclk_prev) begin
      sclk_prev = sclk_o;
      if (sclk_o) begin
        if (rises < 512) mosi_seen[rises] = mosi_o;
        rises++;
      end else begin
        miso_i = miso_pat[rises];
      end
    end
  end

  // mosi must hold while sclk is high (R7)
  always @(negedge clk_i) begin
    if (sclk_o && (mosi_o != smp_mosi)) mosi_bad++;
    smp_mosi = mosi_o;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_txn(input bit fd, input int c, input int a, input int w,
                         input int d, input int r, input logic [15:0] cmd,
                         input logic [63:0] addr, input logic [31:0] tx,
                         input bit inject, input string len_tag);
    int ce, ae, we, de, re, nb, n, k, nd, mis_d, mis_z, bad0;
    logic [31:0] rx_exp;
    logic        exp_bits [0:511];
    ce = (c > 16) ? 16 : c;
    ae = (a > 64) ? 64 : a;
    we = (w > 32) ? 32 : w;
    re = (r > 32) ? 32 : r;
    de = d;
    nb = fd ? (ce + ae + we) : (ce + ae + we + de + re);
    for (int i = 0; i < 16; i++) miso_pat[i*32 +: 32] = $urandom;
    k = 0;
    for (int i = ce - 1; i >= 0; i--) begin exp_bits[k] = cmd[i]; k++; end
    for (int i = ae - 1; i >= 0; i--) begin exp_bits[k] = addr[i]; k++; end
    for (int i = we - 1; i >= 0; i--) begin exp_bits[k] = tx[i]; k++; end
    nd = k;
    while (k < nb) begin exp_bits[k] = 1'b0; k++; end
    rx_exp = '0;
    if (fd) begin
      for (int j = 0; j < ((re < we) ? re : we); j++)
        rx_exp = {rx_exp[30:0], miso_pat[ce + ae + j]};
    end else begin
      for (int j = 0; j < re; j++)
        rx_exp = {rx_exp[30:0], miso_pat[ce + ae + we + de + j]};
    end

    @(negedge clk_i);
    full_duplex_i = fd;
    cmd_len_i     = 5'(c);
    addr_len_i    = 7'(a);
    tx_len_i      = 6'(w);
    rx_len_i      = 6'(r);
    dummy_len_i   = 8'(d);
    cmd_i         = cmd;
    addr_i        = addr;
    tx_data_i     = tx;
    start_i       = 1'b1;
    bad0          = mosi_bad;
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
      if (n == 1) begin
        start_i = 1'b0;
        check(busy_o && !cs_no, "R8", "busy/cs one cycle after start",
              {62'd0, busy_o, cs_no}, 64'h2);
      end
      if (inject && n == 3) begin
        start_i       = 1'b1;
        full_duplex_i = !fd;
        cmd_len_i     = '0;
        tx_data_i     = ~tx;
      end
      if (inject && n == 4) start_i = 1'b0;
    end while (!done_o && n < 20000);

    check(n == (2 * nb + 1) * HALF + 1, (nb == 0) ? "R10" : "R8",
          "cycles to done", 64'(n), 64'((2 * nb + 1) * HALF + 1));
    check(cs_no && !busy_o && !sclk_o, "R8", "pins at done",
          {61'd0, cs_no, busy_o, sclk_o}, 64'h4);
    check(rises == nb, (len_tag != "") ? len_tag : (fd ? "R6" : "R2"),
          "sclk rising edges", 64'(rises), 64'(nb));
    mis_d = 0;
    mis_z = 0;
    for (int i = 0; i < nb && i < rises && i < 512; i++) begin
      if (mosi_seen[i] !== exp_bits[i]) begin
        if (i < nd) mis_d++;
        else mis_z++;
      end
    end
    check(mis_d == 0, inject ? "R9" : "R2", "mosi bits wrong in cmd/addr/write",
          64'(mis_d), 64'd0);
    if (!fd) check(mis_z == 0, "R4", "mosi not low in dummy/read",
                   64'(mis_z), 64'd0);
    check(rx_data_o == rx_exp, fd ? "R6" : "R5", "receive word",
          64'(rx_data_o), 64'(rx_exp));
    check(mosi_bad == bad0, "R7", "mosi changed while sclk high",
          64'(mosi_bad - bad0), 64'd0);
    @(negedge clk_i);
    check(!done_o, "R8", "done longer than one cycle", 64'(done_o), 64'd0);
    if (inject) begin
      repeat (8) @(negedge clk_i);
      check(!busy_o && cs_no && !done_o, "R9", "second transaction started",
            {61'd0, busy_o, cs_no, done_o}, 64'h2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk_i);
    check(cs_no && !sclk_o && !mosi_o && !busy_o && !done_o, "R1", "pins in reset",
          {59'd0, cs_no, sclk_o, mosi_o, busy_o, done_o}, 64'h10);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    check(cs_no && !sclk_o && !mosi_o && !busy_o && !done_o, "R1", "pins after reset",
          {59'd0, cs_no, sclk_o, mosi_o, busy_o, done_o}, 64'h10);

    // directed corners
    run_txn(1'b0, 0, 0, 0, 0, 0, 16'h0, 64'h0, 32'h0, 1'b0, "R10");
    run_txn(1'b0, 8, 24, 16, 4, 16, 16'h00A5, 64'h00C0FFEE, 32'h0000BEEF, 1'b0, "");
    run_txn(1'b0, 0, 0, 0, 3, 8, 16'h0, 64'h0, 32'h0, 1'b0, "R4");
    run_txn(1'b0, 31, 100, 63, 1, 40, 16'hF00D, 64'hDEAD_BEEF_0123_4567,
            32'h89AB_CDEF, 1'b0, "R3");
    run_txn(1'b1, 4, 8, 32, 9, 12, 16'h000C, 64'h5A, 32'h1234_5678, 1'b0, "R6");
    run_txn(1'b1, 0, 0, 10, 0, 32, 16'h0, 64'h0, 32'h0000_02AB, 1'b0, "R6");
    run_txn(1'b0, 16, 0, 0, 255, 0, 16'h8001, 64'h0, 32'h0, 1'b0, "R4");
    run_txn(1'b0, 8, 8, 8, 2, 8, 16'h00F0, 64'h3C, 32'h0F, 1'b1, "");
    run_txn(1'b0, 0, 64, 0, 0, 0, 16'h0, 64'h8000_0000_0000_0001, 32'h0, 1'b0, "");

    // random mix
    for (int t = 0; t < 30; t++) begin
      bit          fd;
      int          c, a, w, d, r;
      logic [15:0] cv;
      logic [63:0] av;
      logic [31:0] tv;
      fd = 1'($urandom_range(0, 1));
      c  = $urandom_range(0, 16);
      a  = $urandom_range(0, 64);
      w  = $urandom_range(0, 32);
      d  = $urandom_range(0, 6);
      r  = $urandom_range(0, 32);
      cv = 16'($urandom);
      av = {$urandom, $urandom};
      tv = $urandom;
      run_txn(fd, c, a, w, d, r, cv, av, tv, (t % 7) == 3 && (c + a + w) >= 4, "");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule